// File: doc/BRIEF.md
# Nonvolatile Memory Write-Erase Controller

This block is the CPU-facing control point for on-chip nonvolatile storage. Software programs one byte-wide control register that selects the target space (data EEPROM, program memory or configuration space). The same register enables writing, arms an erase and starts a read or a write. The block turns those settings into request, space-select and read/write/erase levels towards a memory macro. It holds them until the macro reports completion.

A second bus address holds no data and always reads as zero. It takes a two-byte unlock key, which must come immediately before any write start. Start bits can only be set by software and are cleared by hardware on completion. A finished write raises a sticky completion flag that is also driven out as an interrupt request. A warm (master or watchdog) reset that cuts a write short leaves a sticky error bit for software to inspect. The block distinguishes power-on reset through the `por_n` qualifier, which is sampled while `rst_n` is low.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: A reset with `por_n` low clears every control bit, including the error bit, so the control register (offset 0) reads 0x00 and all memory-side outputs are 0.
- R2: Control bit layout: b7 program select, b6 config select, b5 completion flag, b4 erase arm, b3 write error, b2 write enable, b1 write start, b0 read start. `mem_space` is 2 (config) when b6 is 1, otherwise 1 (program) when b7 is 1, otherwise 0 (data EEPROM).
- R3: Writing 1 to b1 starts a write only if the two bus accesses just before were writes of 0x55 and then 0xAA to the key address (offset 1). Any other access, read or write, cancels the key.
- R4: A write start is ignored unless b2 was already 1 before the starting bus write.
- R5: While a write is pending, `mem_req` is 1. `mem_erase` is 1 if b4 was 1 at the start, otherwise `mem_write` is 1. While a read is pending, `mem_req` and `mem_read` are 1.
- R6: Writing 0 to b0 or b1 never clears them. A pending start bit clears at the clock edge where `mem_done` is 1.
- R7: A read start is ignored when the same bus write sets b7.
- R8: While a write is pending, bus writes do not change b7, b6 or b4.
- R9: The key address always reads 0x00.
- R10: b5 and `irq_done` are set when a write completes, not when a read completes. Writing 0 to b5 clears it. Writing 1 to b5 has no effect.
- R11: A reset with `por_n` high while a write is pending sets b3. b3 survives further such resets and is cleared only by a reset with `por_n` low or by writing 0 to it. All other bits clear on any reset.
- R12: Read and write starts are ignored while `mem_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of any cause |
| por_n | input | 1 | Low while `rst_n` is low marks a power-on reset |
| bus_addr | input | ADDR_W | CPU register address |
| bus_we | input | 1 | CPU write strobe |
| bus_re | input | 1 | CPU read strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data (combinational) |
| mem_busy | input | 1 | Macro busy with other work |
| mem_done | input | 1 | Macro reports the pending operation complete |
| mem_req | output | 1 | Operation request to the macro |
| mem_space | output | 2 | Target space: 0 data, 1 program, 2 config |
| mem_read | output | 1 | Read operation level |
| mem_write | output | 1 | Write operation level |
| mem_erase | output | 1 | Erase operation level |
| irq_done | output | 1 | Write completion interrupt flag |

## Verification
A wrong internal state shows at the ports within one bus read or one clock. A key state that stays armed, or is aborted by mistake, shows as a start bit that does or does not read back 1 on the next read of offset 0. It also shows on `mem_req` in the following cycle. A lost lock on the selection bits appears as a changed `mem_space` during a pending write. A flag or error bit that is not sticky appears as a zero readback after a clear attempt with a 1, or after a warm reset.

// File: rtl/nvm_seq_pkg.sv
// Shared types and control-byte bit positions for the NVM controller.
// Assumes an 8-bit control register.
package nvm_seq_pkg;
    typedef enum logic [1:0] {
        SPACE_DATA = 2'd0,
        SPACE_PROG = 2'd1,
        SPACE_CFG  = 2'd2
    } nvm_space_e;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    localparam int unsigned B_RD    = 0;
    localparam int unsigned B_WR    = 1;
    localparam int unsigned B_WEN   = 2;
    localparam int unsigned B_ERR   = 3;
    localparam int unsigned B_ERASE = 4;
    localparam int unsigned B_FLAG  = 5;
    localparam int unsigned B_CFG   = 6;
    localparam int unsigned B_PROG  = 7;
endpackage

// File: rtl/nvm_key_fsm.sv
// Unlock key tracker: arms after KEY1 then KEY2 written to the key address
// with no other bus access between them or before the next access.
// Assumes acc is high for every bus read or write cycle.
module nvm_key_fsm
    import nvm_seq_pkg::*;
#(
    parameter logic [7:0] KEY1 = 8'h55,
    parameter logic [7:0] KEY2 = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       key_we,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_state_e st;

    // Advance the key state on every access; anything unexpected drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= KEY_IDLE;
        end else if (acc) begin
            if (key_we && wdata == KEY1)
                st <= KEY_HALF;
            else if (st == KEY_HALF && key_we && wdata == KEY2)
                st <= KEY_ARMED;
            else
                st <= KEY_IDLE;
        end
    end

    assign armed = (st == KEY_ARMED);

    // R3: arming only follows a KEY2 write to the key address
    p_arm_after_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_we && wdata == KEY2));
endmodule

// File: rtl/nvm_ctl_reg.sv
// Control register and operation sequencer: holds selection, enable, flag
// and error bits, accepts set-only start bits and clears them on mem_done.
// Assumes one operation at a time and a single-cycle mem_done pulse.
module nvm_ctl_reg
    import nvm_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic       ctrl_we,
    input  logic [7:0] wdata,
    input  logic       armed,
    input  logic       mem_busy,
    input  logic       mem_done,
    output logic [7:0] ctrl_q,
    output logic       rd_go,
    output logic       wr_go,
    output logic       erase_en,
    output logic [1:0] space
);
    logic sel_prog, sel_cfg, wen, werr, flag;
    logic idle, wr_start, rd_start;

    // Starts need a quiet block and a quiet macro.
    assign idle     = !wr_go && !rd_go && !mem_busy;
    assign wr_start = ctrl_we && wdata[B_WR] && wen && armed && idle;
    assign rd_start = ctrl_we && wdata[B_RD] && !wdata[B_PROG] && idle && !wr_start;

    // Register update: reset split by cause, then software and hardware events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prog <= 1'b0;
            sel_cfg  <= 1'b0;
            erase_en <= 1'b0;
            wen      <= 1'b0;
            flag     <= 1'b0;
            wr_go    <= 1'b0;
            rd_go    <= 1'b0;
            werr     <= por_n & (werr | wr_go);
        end else begin
            if (ctrl_we && !wr_go) begin
                sel_prog <= wdata[B_PROG];
                sel_cfg  <= wdata[B_CFG];
                erase_en <= wdata[B_ERASE];
            end
            if (ctrl_we)
                wen <= wdata[B_WEN];
            if (ctrl_we && !wdata[B_ERR])
                werr <= 1'b0;
            if (wr_go && mem_done)
                flag <= 1'b1;
            else if (ctrl_we && !wdata[B_FLAG])
                flag <= 1'b0;
            if (wr_go && mem_done)
                wr_go <= 1'b0;
            else if (wr_start)
                wr_go <= 1'b1;
            if (rd_go && mem_done)
                rd_go <= 1'b0;
            else if (rd_start)
                rd_go <= 1'b1;
        end
    end

    // Target space: configuration overrides the program/data choice.
    always_comb begin
        if (sel_cfg)
            space = SPACE_CFG;
        else if (sel_prog)
            space = SPACE_PROG;
        else
            space = SPACE_DATA;
    end

    // Readback byte in the fixed bit layout.
    always_comb begin
        ctrl_q         = 8'h00;
        ctrl_q[B_PROG] = sel_prog;
        ctrl_q[B_CFG]  = sel_cfg;
        ctrl_q[B_FLAG] = flag;
        ctrl_q[B_ERASE]= erase_en;
        ctrl_q[B_ERR]  = werr;
        ctrl_q[B_WEN]  = wen;
        ctrl_q[B_WR]   = wr_go;
        ctrl_q[B_RD]   = rd_go;
    end

    // R3: a write start needs the armed key in the cycle before
    p_wr_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_go) |-> $past(armed && wen));
    // R7: a read never starts with program memory selected
    p_rd_not_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_go) |-> !sel_prog);
    // R8: selection bits frozen while a write stays pending
    p_sel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && $past(wr_go)) |-> $stable({sel_prog, sel_cfg, erase_en}));
    // R6: the write start only falls on completion
    p_wr_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(wr_go)) |-> $past(mem_done));
    // R10: completion of a write raises the flag
    p_flag_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_go && mem_done)) |-> flag);
    // R12: no start while the macro is busy
    p_busy_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(wr_go | rd_go)) |-> !$past(mem_busy));
endmodule

// File: rtl/nvm_seq_ctrl.sv
// Top of the NVM write-erase controller: decodes the two bus addresses,
// returns readback data and drives the memory-macro control levels.
// Assumes single-cycle bus accesses with combinational read data.
module nvm_seq_ctrl
    import nvm_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned KEY_ADDR  = 1,
    parameter logic [7:0]  KEY1      = 8'h55,
    parameter logic [7:0]  KEY2      = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              mem_busy,
    input  logic              mem_done,
    output logic              mem_req,
    output logic [1:0]        mem_space,
    output logic              mem_read,
    output logic              mem_write,
    output logic              mem_erase,
    output logic              irq_done
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);

    logic       ctrl_sel, key_sel, armed;
    logic       rd_go, wr_go, erase_en;
    logic [7:0] ctrl_q;

    assign ctrl_sel = (bus_addr == CTRL_A);
    assign key_sel  = (bus_addr == KEY_A);

    nvm_key_fsm #(.KEY1(KEY1), .KEY2(KEY2)) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (bus_we | bus_re),
        .key_we (bus_we & key_sel),
        .wdata  (bus_wdata),
        .armed  (armed)
    );

    nvm_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_n    (por_n),
        .ctrl_we  (bus_we & ctrl_sel),
        .wdata    (bus_wdata),
        .armed    (armed),
        .mem_busy (mem_busy),
        .mem_done (mem_done),
        .ctrl_q   (ctrl_q),
        .rd_go    (rd_go),
        .wr_go    (wr_go),
        .erase_en (erase_en),
        .space    (mem_space)
    );

    // Read mux: only the control address returns stored bits.
    assign bus_rdata = ctrl_sel ? ctrl_q : 8'h00;

    // Macro levels follow the pending start bits.
    assign mem_req   = rd_go | wr_go;
    assign mem_read  = rd_go;
    assign mem_write = wr_go & ~erase_en;
    assign mem_erase = wr_go & erase_en;
    assign irq_done  = ctrl_q[B_FLAG];

    // R5: write and erase levels never overlap
    p_op_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_read, mem_write, mem_erase}));
    // R9: the key address never returns data
    p_key_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && key_sel) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sim_nvm_seq_ctrl.sv
// Scoreboard bench: driver tasks queue expected bytes, a monitor compares.
module sim_nvm_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mem_busy = 1'b0, mem_done = 1'b0;
    logic       mem_req, mem_read, mem_write, mem_erase, irq_done;
    logic [1:0] mem_space;
    logic       probe_rd = 1'b0, probe_mem = 1'b0;
    int         checks = 0, failures = 0;
    bit         finished = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    nvm_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mem_busy(mem_busy), .mem_done(mem_done),
        .mem_req(mem_req), .mem_space(mem_space), .mem_read(mem_read),
        .mem_write(mem_write), .mem_erase(mem_erase), .irq_done(irq_done)
    );

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (probe_rd || probe_mem) begin
            item_t it;
            logic [7:0] act;
            act = probe_rd ? bus_rdata
                 : {1'b0, mem_req, mem_read, mem_write, mem_erase, mem_space, irq_done};
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty act=%h exp=none", act);
            end else begin
                it = q.pop_front();
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle_cycle();
        @(posedge clk); #1;
        bus_we = 0; bus_re = 0; probe_rd = 0; probe_mem = 0; mem_done = 0;
    endtask
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1;
        idle_cycle();
    endtask
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a; bus_re = 1; probe_rd = 1;
        q.push_back('{e, t});
        idle_cycle();
    endtask
    // Memory vector: {0, req, read, write, erase, space[1:0], irq}
    task automatic mem_chk(input logic [7:0] e, input string t);
        @(posedge clk); #1;
        probe_mem = 1;
        q.push_back('{e, t});
        idle_cycle();
    endtask
    task automatic done_pulse();
        @(posedge clk); #1; mem_done = 1;
        idle_cycle();
    endtask
    task automatic do_reset(input logic por);
        @(posedge clk); #1; rst_n = 0; por_n = por;
        @(posedge clk); #1; rst_n = 1; por_n = 1;
    endtask
    task automatic unlock();
        wr(4'd1, 8'h55);
        wr(4'd1, 8'hAA);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1; por_n = 1;
        rd(0, 8'h00, "R1 ctrl after power-on");
        rd(1, 8'h00, "R9 key address reads zero");
        mem_chk(8'h00, "R1 macro outputs idle");
        wr(0, 8'h40); mem_chk(8'h04, "R2 config select");
        wr(0, 8'hC0); mem_chk(8'h04, "R2 config overrides program");
        wr(0, 8'h80); mem_chk(8'h02, "R2 program select");
        wr(0, 8'h00); mem_chk(8'h00, "R2 data select");
        wr(0, 8'h81); rd(0, 8'h80, "R7 read blocked with program");
        wr(0, 8'h01); rd(0, 8'h01, "R6 read start set");
        mem_chk(8'h60, "R5 read levels");
        wr(0, 8'h00); rd(0, 8'h01, "R6 zero write keeps read start");
        done_pulse(); rd(0, 8'h00, "R10 read completion leaves flag clear");
        unlock(); wr(0, 8'h02); rd(0, 8'h00, "R4 write start without enable");
        wr(0, 8'h04); wr(0, 8'h06); rd(0, 8'h04, "R3 write start without key");
        wr(1, 8'h55); rd(0, 8'h04, "R3 state before aborted key");
        wr(1, 8'hAA); wr(0, 8'h06); rd(0, 8'h04, "R3 read aborts key");
        unlock(); wr(0, 8'h06); rd(0, 8'h06, "R3 keyed write start");
        mem_chk(8'h50, "R5 write levels");
        wr(0, 8'h94); rd(0, 8'h06, "R8 selection frozen while pending");
        mem_chk(8'h50, "R8 macro space unchanged");
        done_pulse(); rd(0, 8'h24, "R10 flag after write completion");
        mem_chk(8'h01, "R10 irq raised");
        wr(0, 8'h04); rd(0, 8'h04, "R10 zero write clears flag");
        wr(0, 8'h24); rd(0, 8'h04, "R10 one write does not set flag");
        wr(0, 8'h94); rd(0, 8'h94, "R2 erase armed with program");
        unlock(); wr(0, 8'h96); mem_chk(8'h4A, "R5 erase levels");
        do_reset(1'b1); rd(0, 8'h08, "R11 warm reset mid-write sets error");
        mem_chk(8'h00, "R11 macro idle after warm reset");
        do_reset(1'b1); rd(0, 8'h08, "R11 error survives warm reset");
        wr(0, 8'h08); rd(0, 8'h08, "R11 one write keeps error");
        do_reset(1'b0); rd(0, 8'h00, "R1 power-on clears error");
        wr(0, 8'h04); unlock(); wr(0, 8'h06); rd(0, 8'h06, "R11 second write pending");
        do_reset(1'b1); rd(0, 8'h08, "R11 error set again");
        wr(0, 8'h00); rd(0, 8'h00, "R11 zero write clears error");
        wr(0, 8'h04);
        @(posedge clk); #1; mem_busy = 1;
        unlock(); wr(0, 8'h06); rd(0, 8'h04, "R12 write start while busy");
        wr(0, 8'h01); rd(0, 8'h00, "R12 read start while busy");
        @(posedge clk); #1; mem_busy = 0;
        idle_cycle();
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard leftover act=%0d exp=0", q.size());
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule